// File: doc/BRIEF.md
# Configurable Carry-Mode Arithmetic/Logic Slice

This block is a single arithmetic and logic slice that is `W` bits wide, 8 by default. A 3-bit operation code picks one of eight operations on two operands: four arithmetic and four logic or pass. The carry that enters the arithmetic operations comes from one of four sources:

- a built-in default for each operation;
- the slice's own carry from the previous clock;
- an externally routed signal;
- the carry from the next lower slice in a chain.

Two source settings are held side by side, and a per-cycle select bit chooses which one applies. This lets a sequencer alternate between, for example, "start a new word" and "continue a wide word".

Carry-out is taken after a programmable most-significant bit position, so narrower counters and adders can signal overflow at their own width. For decrement and subtract, carry signals are borrows: a 1 means "one lower" on the way in and "went negative" on the way out.

A registered copy of carry-out lets several cycles build one wide add or subtract. A static mask is ANDed onto the result before it leaves the slice, so power-of-two counters wrap on their own.

Top module: `cfg_alu_slice`

## Requirements
- R1: Operation codes select the following results. 000 gives A. 101 gives A XOR B. 110 gives A AND B. 111 gives A OR B.
- R2: With the default carry source, the arithmetic codes give these results modulo 2^W. 001 gives A+1. 010 gives A−1. 011 gives A+B. 100 gives A−B.
- R3: The carry-source code selects the carry as follows. 00 is the default. 01 is the registered carry. 10 is `carry_routed`. 11 is `carry_chain`. When `cfg_sel`=0 the code comes from `csrc_a`; when `cfg_sel`=1 it comes from `csrc_b`.
- R4: For increment and add, a selected carry of 1 adds one to the result. For decrement and subtract, a selected carry of 1 gives A−1 or A−B−1, and a carry of 0 gives A or A−B.
- R5: For increment and add, `carry_out` is 1 when the sum of the operand bits up to the tap position, plus the carry, exceeds that field's range. For decrement and subtract, `carry_out` is 1 when that field would go below zero (a borrow).
- R6: The tap bit for `carry_out` is `msb_pos`, not always the top bit. The result keeps all `W` bits whatever the tap position.
- R7: Pass and the logic operations ignore every carry input, and their `carry_out` is 0.
- R8: `result` equals the operation result ANDed bitwise with `mask`.
- R9: `carry_reg` takes the value of `carry_out` on every rising clock edge and is 0 while `rst_n` is low.
- R10: In registered carry mode, the carry used is the `carry_out` of the previous cycle, so two cycles chain into a 2W-bit add or subtract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_a | input | W | Operand A |
| opnd_b | input | W | Operand B |
| func | input | 3 | Operation code |
| cfg_sel | input | 1 | Per-cycle choice of carry-source setting A (0) or B (1) |
| csrc_a | input | 2 | Carry-source code of setting A |
| csrc_b | input | 2 | Carry-source code of setting B |
| carry_routed | input | 1 | Externally routed carry |
| carry_chain | input | 1 | Carry from the adjacent lower slice |
| msb_pos | input | clog2(W) | Bit position that produces carry-out |
| mask | input | W | Static result mask |
| result | output | W | Masked result |
| carry_out | output | 1 | Carry or borrow out at the tap position |
| carry_reg | output | 1 | Carry-out registered from the previous cycle |

## Verification
On every cycle, the assertions check four things: the mask bound on the result, the pass path, the zero carry of the logic operations, and the one-cycle relationship between `carry_out` and `carry_reg`. When the slice increments at full width with the default carry, they also check that `carry_out` marks the all-ones wrap.

Only the bench's scenarios show the following behaviours, because each is compared there against an independent arithmetic model:
- the polarity of routed and chained carries on decrement and subtract;
- the effect of short tap positions on borrow detection;
- two-cycle wide additions and subtractions through the registered carry.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  typedef enum logic [2:0] {
    OP_PASS = 3'd0,
    OP_INC  = 3'd1,
    OP_DEC  = 3'd2,
    OP_ADD  = 3'd3,
    OP_SUB  = 3'd4,
    OP_XOR  = 3'd5,
    OP_AND  = 3'd6,
    OP_OR   = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    CS_DEFAULT = 2'd0,
    CS_LATCHED = 2'd1,
    CS_ROUTED  = 2'd2,
    CS_CHAINED = 2'd3
  } carry_src_e;

  function automatic logic op_is_arith(alu_op_e op);
    return (op == OP_INC) || (op == OP_DEC) || (op == OP_ADD) || (op == OP_SUB);
  endfunction

  // Borrow-style operations: carry signals mean "one lower" / "went negative".
  function automatic logic op_is_borrow(alu_op_e op);
    return (op == OP_DEC) || (op == OP_SUB);
  endfunction

endpackage

// File: rtl/alu_carry_sel.sv
module alu_carry_sel
  import alu_slice_pkg::*;
(
  input  alu_op_e    op,
  input  logic       cfg_sel,
  input  carry_src_e src_a,
  input  carry_src_e src_b,
  input  logic       carry_latched,
  input  logic       carry_routed,
  input  logic       carry_chain,
  output logic       ci_logical
);

  carry_src_e src_act;

  always_comb begin
    src_act = cfg_sel ? src_b : src_a;
    unique case (src_act)
      // Default: +1 for increment, borrow 1 for decrement, none otherwise.
      CS_DEFAULT: ci_logical = (op == OP_INC) || (op == OP_DEC);
      CS_LATCHED: ci_logical = carry_latched;
      CS_ROUTED:  ci_logical = carry_routed;
      CS_CHAINED: ci_logical = carry_chain;
      default:    ci_logical = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_adder.sv
module alu_adder
  import alu_slice_pkg::*;
#(
  parameter int W  = 8,
  localparam int PW = (W > 1) ? $clog2(W) : 1
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           ci_logical,
  input  logic [PW-1:0]  msb_pos,
  output logic [W-1:0]   sum,
  output logic           co_logical
);

  logic [W-1:0] b_eff;
  logic         borrow_op;
  logic [W:0]   chain;
  logic [PW:0]  tap;

  always_comb begin
    borrow_op = op_is_borrow(op);
    unique case (op)
      OP_INC:  b_eff = '0;
      OP_DEC:  b_eff = '1;
      OP_ADD:  b_eff = b;
      OP_SUB:  b_eff = ~b;
      default: b_eff = '0;
    endcase
  end

  // Borrow-style operations take the adder carry inverted.
  assign chain[0] = ci_logical ^ borrow_op;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]     = a[i] ^ b_eff[i] ^ chain[i];
    assign chain[i+1] = (a[i] & b_eff[i]) | (chain[i] & (a[i] ^ b_eff[i]));
  end

  assign tap        = {1'b0, msb_pos} + (PW+1)'(1);
  assign co_logical = op_is_arith(op) & (chain[tap] ^ borrow_op);

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_slice_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  always_comb begin
    unique case (op)
      OP_XOR:  y = a ^ b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      default: y = a;
    endcase
  end

endmodule

// File: rtl/cfg_alu_slice.sv
module cfg_alu_slice
  import alu_slice_pkg::*;
#(
  parameter int W  = 8,
  localparam int PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  opnd_a,
  input  logic [W-1:0]  opnd_b,
  input  logic [2:0]    func,
  input  logic          cfg_sel,
  input  logic [1:0]    csrc_a,
  input  logic [1:0]    csrc_b,
  input  logic          carry_routed,
  input  logic          carry_chain,
  input  logic [PW-1:0] msb_pos,
  input  logic [W-1:0]  mask,
  output logic [W-1:0]  result,
  output logic          carry_out,
  output logic          carry_reg
);

  alu_op_e      op;
  logic         ci_logical;
  logic [W-1:0] arith_y;
  logic [W-1:0] logic_y;
  logic         co_logical;
  logic         creg_q;
  logic         creg_d;
  logic         creg_en;

  assign op = alu_op_e'(func);

  alu_carry_sel u_carry_sel (
    .op            (op),
    .cfg_sel       (cfg_sel),
    .src_a         (carry_src_e'(csrc_a)),
    .src_b         (carry_src_e'(csrc_b)),
    .carry_latched (creg_q),
    .carry_routed  (carry_routed),
    .carry_chain   (carry_chain),
    .ci_logical    (ci_logical)
  );

  alu_adder #(.W(W)) u_adder (
    .op         (op),
    .a          (opnd_a),
    .b          (opnd_b),
    .ci_logical (ci_logical),
    .msb_pos    (msb_pos),
    .sum        (arith_y),
    .co_logical (co_logical)
  );

  alu_logic_unit #(.W(W)) u_logic (
    .op (op),
    .a  (opnd_a),
    .b  (opnd_b),
    .y  (logic_y)
  );

  assign result    = (op_is_arith(op) ? arith_y : logic_y) & mask;
  assign carry_out = co_logical;

  // Next-state logic of the latched carry.
  always_comb begin
    creg_en = 1'b1;
    creg_d  = co_logical;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      creg_q <= 1'b0;
    end else if (creg_en) begin
      creg_q <= creg_d;
    end
  end

  assign carry_reg = creg_q;

endmodule

// File: rtl/alu_slice_chk.sv
module alu_slice_chk
  import alu_slice_pkg::*;
#(
  parameter int W  = 8,
  localparam int PW = (W > 1) ? $clog2(W) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  opnd_a,
  input logic [2:0]    func,
  input logic          cfg_sel,
  input logic [1:0]    csrc_a,
  input logic [1:0]    csrc_b,
  input logic [PW-1:0] msb_pos,
  input logic [W-1:0]  mask,
  input logic [W-1:0]  result,
  input logic          carry_out,
  input logic          carry_reg
);

  logic [1:0] src_now;
  assign src_now = cfg_sel ? csrc_b : csrc_a;

  AST_MASK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (result & ~mask) == '0); // R8

  AST_PASS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (func == 3'd0) |-> (result == (opnd_a & mask))); // R1

  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    ((func == 3'd0) || (func >= 3'd5)) |-> !carry_out); // R7

  AST_CREG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (carry_reg == $past(carry_out))); // R9

  AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((func == 3'd1) && (src_now == 2'd0) && (msb_pos == PW'(W-1)))
      |-> (carry_out == (opnd_a == '1))); // R5

  always @(negedge clk) begin
    if (!rst_n) AST_RESET_CLEAR: assert (carry_reg == 1'b0); // R9
  end

endmodule

bind cfg_alu_slice alu_slice_chk #(.W(W)) u_alu_slice_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .opnd_a    (opnd_a),
  .func      (func),
  .cfg_sel   (cfg_sel),
  .csrc_a    (csrc_a),
  .csrc_b    (csrc_b),
  .msb_pos   (msb_pos),
  .mask      (mask),
  .result    (result),
  .carry_out (carry_out),
  .carry_reg (carry_reg)
);

// File: tb/test_cfg_alu_slice.sv
`timescale 1ns/1ps
module test_cfg_alu_slice;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] opnd_a, opnd_b, mask, result;
  logic [2:0] func, msb_pos;
  logic       cfg_sel, carry_routed, carry_chain, carry_out, carry_reg;
  logic [1:0] csrc_a, csrc_b;

  int checks = 0;
  int fails  = 0;
  bit model_creg = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cfg_alu_slice #(.W(8)) i_cfg_alu_slice (
    .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b), .func(func),
    .cfg_sel(cfg_sel), .csrc_a(csrc_a), .csrc_b(csrc_b),
    .carry_routed(carry_routed), .carry_chain(carry_chain),
    .msb_pos(msb_pos), .mask(mask), .result(result),
    .carry_out(carry_out), .carry_reg(carry_reg)
  );

  task automatic check(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // Behavioural reference: integer arithmetic on the tapped field.
  task automatic model(output int r, output int co);
    int src, ci, m2, am, bm, a, b;
    a  = int'(opnd_a);
    b  = int'(opnd_b);
    src = cfg_sel ? int'(csrc_b) : int'(csrc_a);
    case (src)
      0: ci = (func == 3'd1 || func == 3'd2) ? 1 : 0;
      1: ci = int'(model_creg);
      2: ci = int'(carry_routed);
      default: ci = int'(carry_chain);
    endcase
    m2 = 1 << (int'(msb_pos) + 1);
    am = a % m2;
    bm = b % m2;
    co = 0;
    case (func)
      3'd1: begin r = a + ci;     co = (am + ci >= m2) ? 1 : 0; end
      3'd2: begin r = a - ci;     co = (am < ci) ? 1 : 0; end
      3'd3: begin r = a + b + ci; co = (am + bm + ci >= m2) ? 1 : 0; end
      3'd4: begin r = a - b - ci; co = (am < bm + ci) ? 1 : 0; end
      3'd5: r = a ^ b;
      3'd6: r = a & b;
      3'd7: r = a | b;
      default: r = a;
    endcase
    r = (r & 255) & int'(mask);
  endtask

  task automatic step(input string tag, input logic [2:0] f, input logic [7:0] a,
                      input logic [7:0] b, input logic sel, input logic [1:0] sa,
                      input logic [1:0] sb, input logic rt, input logic ch,
                      input logic [2:0] k, input logic [7:0] m);
    int er, eco;
    @(negedge clk);
    func = f; opnd_a = a; opnd_b = b; cfg_sel = sel; csrc_a = sa; csrc_b = sb;
    carry_routed = rt; carry_chain = ch; msb_pos = k; mask = m;
    #1;
    model(er, eco);
    check(tag, "result", int'(result), er);
    check(tag, "carry_out", int'(carry_out), eco);
    check("R9", "carry_reg", int'(carry_reg), int'(model_creg));
    model_creg = eco[0];
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    func = 3'd0; opnd_a = '0; opnd_b = '0; cfg_sel = 1'b0; csrc_a = 2'd0; csrc_b = 2'd0;
    carry_routed = 1'b0; carry_chain = 1'b0; msb_pos = 3'd7; mask = 8'hFF;
    repeat (3) @(negedge clk);
    check("R9", "carry_reg in reset", int'(carry_reg), 0);
    rst_n = 1'b1;

    // R1 / R7: pass and logic operations, all carry sources driven active
    for (int s = 0; s < 4; s++) begin
      step("R1", 3'd0, 8'hA5, 8'h3C, 1'b0, 2'(s), 2'd0, 1'b1, 1'b1, 3'd7, 8'hFF);
      step("R7", 3'd5, 8'hA5, 8'h3C, 1'b0, 2'(s), 2'd0, 1'b1, 1'b1, 3'd7, 8'hFF);
      step("R1", 3'd6, 8'hA5, 8'h3C, 1'b1, 2'd0, 2'(s), 1'b1, 1'b1, 3'd7, 8'hFF);
      step("R7", 3'd7, 8'hA5, 8'h3C, 1'b1, 2'd0, 2'(s), 1'b1, 1'b1, 3'd7, 8'hFF);
    end

    // R2 / R5: default arithmetic, including wrap and borrow edges
    step("R2", 3'd1, 8'h41, 8'h00, 1'b0, 2'd0, 2'd3, 1'b0, 1'b0, 3'd7, 8'hFF);
    step("R5", 3'd1, 8'hFF, 8'h00, 1'b0, 2'd0, 2'd3, 1'b0, 1'b0, 3'd7, 8'hFF);
    step("R2", 3'd2, 8'h41, 8'h00, 1'b0, 2'd0, 2'd3, 1'b0, 1'b0, 3'd7, 8'hFF);
    step("R5", 3'd2, 8'h00, 8'h00, 1'b0, 2'd0, 2'd3, 1'b0, 1'b0, 3'd7, 8'hFF);
    step("R2", 3'd3, 8'h70, 8'h25, 1'b0, 2'd0, 2'd3, 1'b0, 1'b0, 3'd7, 8'hFF);
    step("R5", 3'd3, 8'hF0, 8'h20, 1'b0, 2'd0, 2'd3, 1'b0, 1'b0, 3'd7, 8'hFF);
    step("R2", 3'd4, 8'h70, 8'h25, 1'b0, 2'd0, 2'd3, 1'b0, 1'b0, 3'd7, 8'hFF);
    step("R5", 3'd4, 8'h10, 8'h25, 1'b0, 2'd0, 2'd3, 1'b0, 1'b0, 3'd7, 8'hFF);

    // R3 / R4: routed and chained polarity, picked through A or B setting
    for (int v = 0; v < 2; v++) begin
      step("R4", 3'd1, 8'h10, 8'h00, 1'b0, 2'd2, 2'd0, 1'(v), 1'b0, 3'd7, 8'hFF);
      step("R4", 3'd2, 8'h10, 8'h00, 1'b0, 2'd2, 2'd0, 1'(v), 1'b0, 3'd7, 8'hFF);
      step("R4", 3'd3, 8'h10, 8'h05, 1'b1, 2'd0, 2'd3, 1'b0, 1'(v), 3'd7, 8'hFF);
      step("R4", 3'd4, 8'h10, 8'h05, 1'b1, 2'd0, 2'd3, 1'b0, 1'(v), 3'd7, 8'hFF);
      step("R3", 3'd3, 8'h10, 8'h05, 1'b0, 2'd3, 2'd2, 1'(v), 1'(1 - v), 3'd7, 8'hFF);
      step("R3", 3'd3, 8'h10, 8'h05, 1'b1, 2'd3, 2'd2, 1'(v), 1'(1 - v), 3'd7, 8'hFF);
    end

    // R6: short tap positions
    step("R6", 3'd1, 8'h0F, 8'h00, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 3'd3, 8'hFF);
    step("R6", 3'd3, 8'h08, 8'h08, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 3'd3, 8'hFF);
    step("R6", 3'd4, 8'h30, 8'h01, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 3'd3, 8'hFF);
    step("R6", 3'd2, 8'h80, 8'h00, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 8'hFF);

    // R8: mask on a power-of-two counter
    step("R8", 3'd1, 8'h0F, 8'h00, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 3'd3, 8'h0F);
    step("R8", 3'd7, 8'hA5, 8'h5A, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 3'd7, 8'h3C);

    // R10: 16-bit add 0x12FF + 0x0001 and 16-bit subtract 0x1200 - 0x0001
    step("R10", 3'd3, 8'hFF, 8'h01, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0, 3'd7, 8'hFF);
    step("R10", 3'd3, 8'h12, 8'h00, 1'b1, 2'd0, 2'd1, 1'b0, 1'b0, 3'd7, 8'hFF);
    step("R10", 3'd4, 8'h00, 8'h01, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0, 3'd7, 8'hFF);
    step("R10", 3'd4, 8'h12, 8'h00, 1'b1, 2'd0, 2'd1, 1'b0, 1'b0, 3'd7, 8'hFF);

    // Mixed random traffic, compared every clock against the model
    for (int i = 0; i < 3000; i++) begin
      step("R2/R5", 3'($urandom), 8'($urandom), 8'($urandom), 1'($urandom),
           2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
           3'($urandom), ($urandom % 4 == 0) ? 8'($urandom) : 8'hFF);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule